// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence of one memory burst inside a row of 256 columns. A read or write command loads a start column, a length code and an ordering choice. From the next cycle on the block presents one column per enabled clock, together with a valid flag and a flag that marks the final beat. It is placed beside a command decoder: the decoder pulses the load input and the array column decoder consumes the output.

Two orderings are available. Linear steps upward inside an aligned window and wraps back to the bottom of that window. Interleaved flips the low bits of the start column according to the beat number. A full-page length steps through the whole row modulo 256 and keeps going until a stop request arrives. A clock-enable input that is low makes the block ignore the edge, so the presented column, valid and last flags all hold.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: When `cke_i` and `start_i` are both 1 at an edge, the next cycle shows `valid_o`=1 and `col_o`=`start_col_i`. This holds during an active burst and also when `stop_i` is 1 at the same edge.
- R3: For `len_code_i` values 0 to 3 the burst has 2^code beats (1, 2, 4, 8). Every other code (4 to 7) selects full page.
- R4: With `ilv_i`=0 and L beats, beat k shows the start column with its low log2(L) bits replaced by (start low bits + k) mod L. The upper bits are unchanged.
- R5: With `ilv_i`=1 and L beats, beat k shows the start column with its low log2(L) bits XORed with k. The upper bits are unchanged.
- R6: In full page, beat k shows (start + k) mod 256 whatever `ilv_i` is. The burst continues past 256 beats until it is stopped.
- R7: `last_o` is 1 only on the final beat of a fixed-length burst, and it is never 1 in full page.
- R8: After the final beat, the next enabled edge clears `valid_o`. `col_o` then holds the last column until the next load.
- R9: When `stop_i`=1 and `cke_i`=1 at an edge with no load, `valid_o` is 0 from the next cycle and `col_o` holds the column shown at that edge.
- R10: An edge with `cke_i`=0 changes nothing. `col_o`, `valid_o` and `last_o` keep their values, and `start_i` and `stop_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Edge enable; low freezes all state |
| start_i | input | 1 | Load a new burst |
| start_col_i | input | 8 | Start column |
| len_code_i | input | 3 | Length code: 0..3 give 1/2/4/8 beats, others full page |
| ilv_i | input | 1 | 1 selects interleaved order, 0 linear |
| stop_i | input | 1 | End the burst in progress |
| col_o | output | 8 | Current column |
| valid_o | output | 1 | Beat valid |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
A wrong beat counter or a stale window mask shows as a wrong column on `col_o` in the very next beat. A bad length decode shows within at most eight beats, because `last_o` fires or `valid_o` drops on the wrong beat. A full-page burst that wrapped or stopped by mistake is caught when the sequence crosses column 255 and again when it passes its own start column. A freeze that leaks shows as any change on the three outputs one cycle after an edge with `cke_i` low.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic {
    ORD_LIN = 1'b0,
    ORD_XOR = 1'b1
  } order_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
  parameter int COL_W   = 8,
  parameter int CODE_W  = 3,
  parameter int MAX_LOG = 3
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [COL_W-1:0]  mask_o,
  output logic              full_o
);
  always_comb begin
    full_o = (int'(code_i) > MAX_LOG);
    for (int i = 0; i < COL_W; i++) begin
      mask_o[i] = full_o | (i < int'(code_i));
    end
  end
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic             full_i,
  input  logic [COL_W-1:0] mask_i,
  output logic [COL_W-1:0] cnt_o,
  output logic             active_o,
  output logic             last_o
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [COL_W-1:0] cnt_q;
  logic             active_q;

  assign last_o   = active_q & ~full_i & (cnt_q == mask_i);
  assign cnt_o    = cnt_q;
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (en_i) begin
      if (load_i) begin
        cnt_q    <= '0;
        active_q <= 1'b1;
      end else if (active_q) begin
        if (stop_i || last_o) active_q <= 1'b0;
        else                  cnt_q    <= cnt_q + ONE;
      end
    end
  end
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum_w;
  logic [COL_W-1:0] flip_w;

  assign sum_w  = base_i + cnt_i;
  assign flip_w = base_i ^ cnt_i;

  for (genvar g = 0; g < COL_W; g++) begin : g_bit
    assign col_o[g] = mask_i[g] ? ((order_i == ORD_XOR) ? flip_w[g] : sum_w[g]) : base_i[g];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int CODE_W  = 3,
  parameter int MAX_LOG = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              ilv_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o
);
  logic             load_w;
  logic [COL_W-1:0] dec_mask_w;
  logic             dec_full_w;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  order_e           order_q;
  logic [COL_W-1:0] cnt_w;

  assign load_w = cke_i & start_i;

  bcg_len_decode #(
    .COL_W  (COL_W),
    .CODE_W (CODE_W),
    .MAX_LOG(MAX_LOG)
  ) i_dec (
    .code_i(len_code_i),
    .mask_o(dec_mask_w),
    .full_o(dec_full_w)
  );

  // full page always walks upward
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      order_q <= ORD_LIN;
    end else if (load_w) begin
      base_q  <= start_col_i;
      mask_q  <= dec_mask_w;
      full_q  <= dec_full_w;
      order_q <= (ilv_i && !dec_full_w) ? ORD_XOR : ORD_LIN;
    end
  end

  bcg_beat_ctr #(.COL_W(COL_W)) i_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cke_i),
    .load_i  (start_i),
    .stop_i  (stop_i),
    .full_i  (full_q),
    .mask_i  (mask_q),
    .cnt_o   (cnt_w),
    .active_o(valid_o),
    .last_o  (last_o)
  );

  bcg_addr_map #(.COL_W(COL_W)) i_map (
    .base_i (base_q),
    .cnt_i  (cnt_w),
    .mask_i (mask_q),
    .order_i(order_q),
    .col_o  (col_o)
  );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cke_i,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && start_i |=> valid_o && col_o == $past(start_col_i)); // R2

  AST_LAST_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R7

  AST_END_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && last_o && !start_i |=> !valid_o && $stable(col_o)); // R8

  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && !valid_o && !start_i |=> !valid_o); // R8

  AST_STOP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && stop_i && !start_i |=> !valid_o && $stable(col_o)); // R9

  AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> $stable(col_o) && $stable(valid_o) && $stable(last_o)); // R10
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) i_bcg_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cke_i      (cke_i),
  .start_i    (start_i),
  .start_col_i(start_col_i),
  .stop_i     (stop_i),
  .col_o      (col_o),
  .valid_o    (valid_o),
  .last_o     (last_o)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cke_i = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o;
  logic       last_o;

  int checks = 0;
  int failures = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #10 clk_i = ~clk_i;

  burst_col_gen i_burst_col_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .start_i(start_i),
    .start_col_i(start_col_i), .len_code_i(len_code_i), .ilv_i(ilv_i),
    .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  // expected column from the ordering rules
  function automatic logic [7:0] ecol(input logic [7:0] b, input logic [2:0] cd,
                                      input logic il, input int k);
    logic [7:0] m;
    logic [7:0] kk;
    kk = 8'(k);
    if (cd > 3) return b + kk;
    m = 8'((1 << cd) - 1);
    if (il) return (b & ~m) | ((b ^ kk) & m);
    return (b & ~m) | ((b + kk) & m);
  endfunction

  task automatic step(input logic st, input logic [7:0] c, input logic [2:0] cd,
                      input logic il, input logic sp, input logic ce,
                      input logic [7:0] ec, input logic ev, input logic el,
                      input string tag);
    @(negedge clk_i);
    start_i = st; start_col_i = c; len_code_i = cd; ilv_i = il;
    stop_i = sp; cke_i = ce;
    exp_q.push_back({ec, ev, el});
    tag_q.push_back(tag);
  endtask

  task automatic burst(input logic [7:0] b, input logic [2:0] cd, input logic il,
                       input int stop_k, input int extra, input string tag);
    bit full;
    int len;
    int k;
    bit done;
    logic [7:0] cur;
    full = (cd > 3);
    len  = full ? 0 : (1 << cd);
    cur  = ecol(b, cd, il, 0);
    step(1, b, cd, il, 0, 1, cur, 1, !full && len == 1, {tag, " R2 R7"});
    k = 0; done = 0;
    while (!done) begin
      if (k == stop_k) begin
        step(0, 8'h00, 3'd0, 0, 1, 1, cur, 0, 0, "R9");
        done = 1;
      end else if (!full && k == len - 1) begin
        step(0, 8'h00, 3'd0, 0, 0, 1, cur, 0, 0, "R8");
        done = 1;
      end else begin
        k++;
        cur = ecol(b, cd, il, k);
        step(0, 8'h00, 3'd0, 0, 0, 1, cur, 1, !full && k == len - 1, {tag, " R7"});
      end
    end
    for (int i = 0; i < extra; i++) step(0, 8'h00, 3'd0, 0, 0, 1, cur, 0, 0, "R8");
  endtask

  always @(posedge clk_i) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [9:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({col_o, valid_o, last_o} !== e) begin
        failures++;
        $display("FAIL %s: col=%02h valid=%0b last=%0b expected col=%02h valid=%0b last=%0b",
                 t, col_o, valid_o, last_o, e[9:2], e[1], e[0]);
      end
    end
  end

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] c;
    #35;
    checks++;
    if (col_o !== 8'h00 || valid_o !== 1'b0 || last_o !== 1'b0) begin
      failures++;
      $display("FAIL R1: col=%02h valid=%0b last=%0b expected col=00 valid=0 last=0",
               col_o, valid_o, last_o);
    end
    rst_ni = 1'b1;

    burst(8'h35, 3'd3, 0, -1, 1, "R4 R3");
    burst(8'h35, 3'd3, 1, -1, 1, "R5 R3");
    burst(8'h4E, 3'd2, 0, -1, 1, "R4 R3");
    burst(8'h4E, 3'd2, 1, -1, 0, "R5 R3");
    burst(8'h77, 3'd1, 0, -1, 0, "R4 R3");
    burst(8'h77, 3'd1, 1, -1, 0, "R5 R3");
    burst(8'hA9, 3'd0, 0, -1, 2, "R3");
    burst(8'hFE, 3'd7, 1, 259, 1, "R6");
    burst(8'h10, 3'd4, 0, 5, 1, "R6 R3");
    burst(8'h20, 3'd5, 1, 2, 0, "R6 R3");
    burst(8'h62, 3'd3, 0, 3, 1, "R4 R9");

    // restart during a burst, and load beating stop
    step(1, 8'h10, 3'd2, 0, 0, 1, 8'h10, 1, 0, "R2");
    step(0, 8'h00, 3'd0, 0, 0, 1, 8'h11, 1, 0, "R4");
    step(1, 8'h83, 3'd3, 1, 1, 1, 8'h83, 1, 0, "R2 restart");
    step(0, 8'h00, 3'd0, 0, 0, 1, 8'h82, 1, 0, "R5");

    // freeze mid-burst; start and stop must be ignored
    c = ecol(8'h35, 3'd3, 0, 0);
    step(1, 8'h35, 3'd3, 0, 0, 1, c, 1, 0, "R2");
    step(1, 8'hC0, 3'd0, 1, 1, 0, c, 1, 0, "R10");
    step(0, 8'h00, 3'd0, 0, 1, 0, c, 1, 0, "R10");
    for (int k = 1; k < 8; k++) begin
      c = ecol(8'h35, 3'd3, 0, k);
      step(0, 8'h00, 3'd0, 0, 0, 1, c, 1, k == 7, "R4 R7");
      if (k == 7) step(0, 8'h00, 3'd0, 0, 0, 0, c, 1, 1, "R10 R7");
    end
    step(0, 8'h00, 3'd0, 0, 0, 1, c, 0, 0, "R8");
    step(1, 8'h44, 3'd1, 0, 0, 0, c, 0, 0, "R10");
    step(0, 8'h00, 3'd0, 0, 0, 1, c, 0, 0, "R8");

    @(negedge clk_i);
    @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule